// File: doc/BRIEF.md
# Tagged Table Allocation Selector

This block decides, at branch-update time, whether a predictor with several tagged history tables should claim a fresh entry after a wrong prediction, and in which table. The tables are numbered from shortest history (index 0) to longest. The caller provides the following each cycle:
- the table that supplied the prediction (its valid flag and its index);
- a per-table flag saying that the table missed and its usefulness bit is clear;
- the mispredict flag, the alternate-used flag and the provider-correct flag.

The block answers in the same cycle with a one-hot table select.

A pressure counter runs alongside the selector. It rises when more of the longer tables are blocked than free, and falls in the opposite case. When it reaches its top value, the block emits a one-cycle pulse that asks the tables to clear all usefulness bits, and the counter starts over. A free-running shift register supplies the random bits that spread allocations across the eligible tables.

Top module: `tage_alloc_sel`

## Requirements
- R1: An allocation is needed when `upd_valid` and `mispred` are both 1, unless `alt_used`, `provider_valid` and `provider_correct` are all 1.
- R2: When `provider_valid` is 1, only tables with an index strictly greater than `provider_idx` are eligible. When it is 0, all tables are eligible.
- R3: The candidate set is the eligible tables with `allocatable` bit 1. The failure set is the eligible tables with `allocatable` bit 0.
- R4: `alloc_onehot` combinationally selects the lowest-indexed table in (candidates AND the low four random bits). If that intersection is empty, it selects the lowest-indexed candidate.
- R5: `alloc_onehot` is all zeros when no allocation is needed, or when the candidate set is empty.
- R6: The random source is a 16-bit shift register. It holds 16'hACE1 while `rst_n` is 0. On each later clock it shifts left by one, and the new bit 0 is the XOR of bits 15, 13, 12 and 10 of the old value. Bits [3:0] are the random bits used in R4.
- R7: After reset the pressure counter is 0, its distance-to-top value is 64, and `reset_useful` is 0.
- R8: On a clock with an allocation needed and more failures than candidates, the counter rises by the difference and the distance falls by it. If the difference is at least the distance, the counter becomes 127 and the distance 0. With equal counts, nothing changes.
- R9: On a clock with an allocation needed and more candidates than failures, the counter falls by the difference and the distance rises by it. If the difference is at least the counter, the counter becomes 0 and the distance 127.
- R10: `reset_useful` is 1 exactly while the counter equals 127. On the next clock the counter becomes 0 and the distance 127, whatever the update inputs are, so the pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | 1 | An update is presented this cycle |
| mispred | input | 1 | The update's prediction was wrong |
| alt_used | input | 1 | The alternate prediction was used |
| provider_valid | input | 1 | A tagged table supplied the prediction |
| provider_idx | input | 2 | Index of the supplying table |
| provider_correct | input | 1 | The supplying table's direction was correct |
| allocatable | input | 4 | Per table: missed and usefulness bit clear |
| alloc_onehot | output | 4 | Table chosen for allocation, or zero |
| reset_useful | output | 1 | One-cycle request to clear all usefulness bits |

## Verification
Faults in the pressure counter or its distance value never show at once. They show only as a `reset_useful` pulse arriving early, late or never, often dozens of updates after the fault. The bench therefore keeps its own counter model and compares the pulse on every cycle, across long climbs to the top, climbs after partial descents, and floor saturation. A random-source fault shows within one update as a different table choice. So every allocation is compared against a shift-register model that steps on every clock, including idle ones.

// File: rtl/tage_alloc_pkg.sv
package tage_alloc_pkg;

   typedef enum logic [1:0] {
      TICK_HOLD = 2'd0,
      TICK_UP   = 2'd1,
      TICK_DOWN = 2'd2
   } tick_dir_e;

endpackage

// File: rtl/tas_lfsr.sv
module tas_lfsr #(
   parameter int            W    = 16,
   parameter logic [W-1:0]  TAPS = 16'hB400,
   parameter logic [W-1:0]  SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state
);
   if (SEED == '0) begin : g_bad_seed
      $error("tas_lfsr: seed must be non-zero");
   end
   if (TAPS == '0) begin : g_bad_taps
      $error("tas_lfsr: tap mask must be non-zero");
   end

   logic [W-1:0] q;
   logic         fb;

   assign fb = ^(q & TAPS);

   always_ff @(posedge clk) begin
      if (!rst_n) q <= SEED;
      else        q <= {q[W-2:0], fb};
   end

   assign state = q;
endmodule

// File: rtl/tas_alloc_pick.sv
module tas_alloc_pick #(
   parameter int N = 4
) (
   input  logic         need,
   input  logic [N-1:0] cand,
   input  logic [N-1:0] rnd,
   output logic [N-1:0] onehot
);
   logic [N-1:0] masked;
   logic [N-1:0] low_masked;
   logic [N-1:0] low_cand;

   assign masked     = cand & rnd;
   assign low_masked = masked & (~masked + 1'b1);
   assign low_cand   = cand & (~cand + 1'b1);

   always_comb begin
      onehot = '0;
      if (need) begin
         if (masked != '0) onehot = low_masked;
         else              onehot = low_cand;
      end
   end
endmodule

// File: rtl/tas_tick.sv
module tas_tick
   import tage_alloc_pkg::*;
#(
   parameter int TICK_W = 7,
   parameter int CNT_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             need,
   input  logic [CNT_W-1:0] n_cand,
   input  logic [CNT_W-1:0] n_fail,
   output logic             fire
);
   localparam logic [TICK_W-1:0] TOP       = {TICK_W{1'b1}};
   localparam logic [TICK_W-1:0] INIT_DIST = TICK_W'(1) << (TICK_W - 1);

   if (CNT_W > TICK_W) begin : g_bad_width
      $error("tas_tick: count width exceeds counter width");
   end

   logic [TICK_W-1:0] tick_q, dist_q, tick_d, dist_d, diff;
   tick_dir_e         dir;

   always_comb begin
      dir  = TICK_HOLD;
      diff = '0;
      if (need && (n_fail > n_cand)) begin
         dir  = TICK_UP;
         diff = TICK_W'(n_fail - n_cand);
      end else if (need && (n_cand > n_fail)) begin
         dir  = TICK_DOWN;
         diff = TICK_W'(n_cand - n_fail);
      end
   end

   always_comb begin
      tick_d = tick_q;
      dist_d = dist_q;
      unique case (dir)
         TICK_UP: begin
            if (diff >= dist_q) begin
               tick_d = TOP;
               dist_d = '0;
            end else begin
               tick_d = tick_q + diff;
               dist_d = dist_q - diff;
            end
         end
         TICK_DOWN: begin
            if (diff >= tick_q) begin
               tick_d = '0;
               dist_d = TOP;
            end else begin
               tick_d = tick_q - diff;
               dist_d = dist_q + diff;
            end
         end
         default: ;
      endcase
      if (tick_q == TOP) begin
         tick_d = '0;
         dist_d = TOP;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_q <= '0;
         dist_q <= INIT_DIST;
      end else begin
         tick_q <= tick_d;
         dist_q <= dist_d;
      end
   end

   assign fire = (tick_q == TOP);
endmodule

// File: rtl/tage_alloc_sel.sv
module tage_alloc_sel #(
   parameter int                  NUM_TABLES = 4,
   parameter int                  TICK_W     = 7,
   parameter int                  LFSR_W     = 16,
   parameter logic [LFSR_W-1:0]   LFSR_TAPS  = 16'hB400,
   parameter logic [LFSR_W-1:0]   LFSR_SEED  = 16'hACE1,
   localparam int                 IDX_W      = $clog2(NUM_TABLES),
   localparam int                 CNT_W      = $clog2(NUM_TABLES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  upd_valid,
   input  logic                  mispred,
   input  logic                  alt_used,
   input  logic                  provider_valid,
   input  logic [IDX_W-1:0]      provider_idx,
   input  logic                  provider_correct,
   input  logic [NUM_TABLES-1:0] allocatable,
   output logic [NUM_TABLES-1:0] alloc_onehot,
   output logic                  reset_useful
);
   if (NUM_TABLES < 2) begin : g_bad_tables
      $error("tage_alloc_sel: need at least two tables");
   end
   if (LFSR_W < 16 || LFSR_W < NUM_TABLES) begin : g_bad_lfsr
      $error("tage_alloc_sel: random source too narrow");
   end
   if (TICK_W < CNT_W + 1) begin : g_bad_tick
      $error("tage_alloc_sel: pressure counter too narrow");
   end

   logic [LFSR_W-1:0]     lfsr_q;
   logic [NUM_TABLES-1:0] longer, cand, fail;
   logic [CNT_W-1:0]      n_cand, n_fail;
   logic                  need;

   assign need = upd_valid && mispred &&
                 !(alt_used && provider_valid && provider_correct);

   for (genvar t = 0; t < NUM_TABLES; t++) begin : g_longer
      assign longer[t] = !provider_valid || (IDX_W'(t) > provider_idx);
   end

   assign cand   = allocatable & longer;
   assign fail   = ~allocatable & longer;
   assign n_cand = CNT_W'($countones(cand));
   assign n_fail = CNT_W'($countones(fail));

   tas_lfsr #(
      .W    (LFSR_W),
      .TAPS (LFSR_TAPS),
      .SEED (LFSR_SEED)
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .state (lfsr_q)
   );

   tas_alloc_pick #(
      .N (NUM_TABLES)
   ) u_pick (
      .need   (need),
      .cand   (cand),
      .rnd    (lfsr_q[NUM_TABLES-1:0]),
      .onehot (alloc_onehot)
   );

   tas_tick #(
      .TICK_W (TICK_W),
      .CNT_W  (CNT_W)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .need   (need),
      .n_cand (n_cand),
      .n_fail (n_fail),
      .fire   (reset_useful)
   );
endmodule

// File: rtl/tage_alloc_sel_chk.sv
module tage_alloc_sel_chk #(
   parameter int NUM_TABLES = 4,
   parameter int IDX_W      = 2,
   parameter int LFSR_W     = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  upd_valid,
   input logic                  mispred,
   input logic                  alt_used,
   input logic                  provider_valid,
   input logic [IDX_W-1:0]      provider_idx,
   input logic                  provider_correct,
   input logic [NUM_TABLES-1:0] allocatable,
   input logic [NUM_TABLES-1:0] alloc_onehot,
   input logic                  reset_useful,
   input logic [LFSR_W-1:0]     lfsr_q
);
   assert_single_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(alloc_onehot));

   assert_pick_allocatable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_onehot & ~allocatable) == '0);

   assert_pick_longer_R2: assert property (@(posedge clk) disable iff (!rst_n)
      provider_valid |-> ((alloc_onehot >> provider_idx) & 1) == 0 &&
                         (alloc_onehot & ((1 << provider_idx) - 1)) == '0);

   assert_no_pick_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_valid && mispred) |-> alloc_onehot == '0);

   assert_no_pick_alt_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (alt_used && provider_valid && provider_correct) |-> alloc_onehot == '0);

   assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reset_useful |=> !reset_useful);

   assert_lfsr_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);
endmodule

bind tage_alloc_sel tage_alloc_sel_chk #(
   .NUM_TABLES (NUM_TABLES),
   .IDX_W      (IDX_W),
   .LFSR_W     (LFSR_W)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .upd_valid        (upd_valid),
   .mispred          (mispred),
   .alt_used         (alt_used),
   .provider_valid   (provider_valid),
   .provider_idx     (provider_idx),
   .provider_correct (provider_correct),
   .allocatable      (allocatable),
   .alloc_onehot     (alloc_onehot),
   .reset_useful     (reset_useful),
   .lfsr_q           (lfsr_q)
);

// File: tb/tb_tage_alloc_sel.sv
module tb_tage_alloc_sel;
   localparam int PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       upd_valid = 1'b0, mispred = 1'b0, alt_used = 1'b0;
   logic       provider_valid = 1'b0, provider_correct = 1'b0;
   logic [1:0] provider_idx = '0;
   logic [3:0] allocatable = '0;
   logic [3:0] alloc_onehot;
   logic       reset_useful;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(PERIOD/2) clk = ~clk;

   tage_alloc_sel dut (
      .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .mispred(mispred),
      .alt_used(alt_used), .provider_valid(provider_valid),
      .provider_idx(provider_idx), .provider_correct(provider_correct),
      .allocatable(allocatable), .alloc_onehot(alloc_onehot),
      .reset_useful(reset_useful)
   );

   // independent model of the random source (R6)
   logic [15:0] m_lfsr;
   always @(posedge clk) begin
      if (!rst_n) m_lfsr <= 16'hACE1;
      else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
   end

   int m_tick = 0;
   int m_dist = 64;

   typedef struct {
      logic [3:0] exp_alloc;
      logic       exp_rst;
      string      atag;
      string      rtag;
   } item_t;
   item_t q[$];
   event chk_ev;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   initial begin
      forever begin
         @(chk_ev);
         while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(it.atag, alloc_onehot, it.exp_alloc);
            check(it.rtag, reset_useful, it.exp_rst);
         end
      end
   end

   function automatic logic [3:0] lowest(input logic [3:0] x);
      for (int i = 0; i < 4; i++) if (x[i]) return 4'(1 << i);
      return 4'd0;
   endfunction

   task automatic step(input logic v, input logic m, input logic a,
                       input logic pv, input logic [1:0] pi, input logic pc,
                       input logic [3:0] al, input string atag, input string rtag);
      logic need;
      logic [3:0] lng, cand, fl, mk;
      int nc, nf, diff;
      item_t it;
      @(negedge clk);
      upd_valid = v; mispred = m; alt_used = a; provider_valid = pv;
      provider_idx = pi; provider_correct = pc; allocatable = al;
      need = v && m && !(a && pv && pc);
      for (int t = 0; t < 4; t++) lng[t] = !pv || (t > pi);
      cand = al & lng;
      fl = ~al & lng;
      nc = $countones(cand);
      nf = $countones(fl);
      it.exp_alloc = 4'd0;
      if (need && cand != 0) begin
         mk = cand & m_lfsr[3:0];
         it.exp_alloc = (mk != 0) ? lowest(mk) : lowest(cand);
      end
      it.exp_rst = (m_tick == 127);
      it.atag = atag;
      it.rtag = rtag;
      q.push_back(it);
      #(PERIOD/4);
      ->chk_ev;
      @(posedge clk);
      if (m_tick == 127) begin
         m_tick = 0; m_dist = 127;
      end else if (need && nf > nc) begin
         diff = nf - nc;
         if (diff >= m_dist) begin m_tick = 127; m_dist = 0; end
         else begin m_tick += diff; m_dist -= diff; end
      end else if (need && nc > nf) begin
         diff = nc - nf;
         if (diff >= m_tick) begin m_tick = 0; m_dist = 127; end
         else begin m_tick -= diff; m_dist += diff; end
      end
   endtask

   initial begin
      #(PERIOD*200000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R7: reset state
      check("R7", reset_useful, 0);
      check("R7", alloc_onehot, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: alternate used and provider correct suppresses allocation
      step(1, 1, 1, 1, 2'd0, 1, 4'b1110, "R1", "R7");
      // R1: misprediction without valid update
      step(0, 1, 0, 0, 2'd0, 0, 4'b1111, "R1", "R8");
      // R1: provider wrong still allocates even with alt used
      step(1, 1, 1, 1, 2'd0, 0, 4'b1110, "R1", "R8");
      // R5: provider is the longest table, no candidates
      step(1, 1, 0, 1, 2'd3, 0, 4'b1111, "R5", "R8");
      // R2: provider at 1, lower allocatable bits must be ignored
      step(1, 1, 0, 1, 2'd1, 0, 4'b0011, "R2", "R8");
      step(1, 1, 0, 1, 2'd1, 0, 4'b1011, "R2", "R8");
      // R3: only allocatable eligible tables
      step(1, 1, 0, 1, 2'd0, 0, 4'b0100, "R3", "R8");

      // R4/R6: varied patterns across many random states
      for (int k = 0; k < 48; k++) begin
         step(1, 1, k[4], k[3], 2'(k * 3), k[5], 4'(k * 7 + 5), "R4", "R9");
         if (k % 5 == 0) step(0, 0, 0, 0, 2'd0, 0, 4'd0, "R6", "R9");
      end

      // settle counter to a known low point: many all-candidate updates
      for (int k = 0; k < 40; k++) step(1, 1, 0, 0, 2'd0, 0, 4'b1111, "R6", "R9");

      // R8/R10: climb with four failures per update until pulse and beyond
      for (int k = 0; k < 45; k++) step(1, 1, 0, 0, 2'd0, 0, 4'b0000, "R4", "R10");

      // R9: partial descent, then climb again (update during pulse)
      for (int k = 0; k < 10; k++) step(1, 1, 0, 1, 2'd0, 0, 4'b1110, "R9", "R9");
      for (int k = 0; k < 60; k++) step(1, 1, 0, 1, 2'd0, 0, 4'b0010, "R8", "R10");
      // R8: equal counts hold
      for (int k = 0; k < 20; k++) step(1, 1, 0, 0, 2'd0, 0, 4'b0011, "R8", "R8");
      for (int k = 0; k < 80; k++) step(1, 1, 0, 0, 2'd0, 0, 4'b0001, "R8", "R10");
      step(0, 0, 0, 0, 2'd0, 0, 4'd0, "R5", "R10");

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule